// File: doc/BRIEF.md
# Flash chip erase sequencer

This block is a host-side controller that carries out a complete bulk erase of an attached parallel NOR-style flash using the device's command-register interface. On a start pulse it raises the high-voltage programming-supply enable. It then has an attached byte-program engine zero every location from address 0 up to `last_addr`, over a request/acknowledge handshake. After that it alternates erase pulses with a per-byte verify sweep.

The verify sweep shares one pulse budget across the whole chip. When a byte reads back anything other than FFh, the controller applies another erase pulse to the whole chip and resumes checking at the byte that failed, rather than starting the sweep again. The run ends in one of two ways: every byte up to `last_addr` passes, or the budget of `MAX_PULSES` is used up. Either way the controller writes the read-mode command, drops the supply enable, and pulses `done` or `error`. A sticky status pair records the outcome until the next accepted start.

All waits are counted by one down-counter. Its load values are derived at elaboration from `CLK_HZ`, `ERASE_NS` and `VERIFY_NS`, rounded up to whole cycles.

Top module: `flash_erase_seq`

## Requirements
- R1: `start` is accepted only while `busy` is low; an accepted start raises `busy` on the next cycle and clears `stat_pass` and `stat_fail`; a start while busy has no effect on the run or its counts, and a start in the cycle that shows `done`/`error` is also ignored.
- R2: Before the first erase command, `pp_req` is raised with `fl_addr` set to each address from 0 to `last_addr` in ascending order, and each address advances on one `pp_ack` pulse, so every byte holds 00h before any erase.
- R3: `vpp_en` rises on the accepted start and is high during every command write; it is already low in the cycle where `done` or `error` is shown.
- R4: An erase pulse is two consecutive command writes of data 20h. From the release of write-enable after the second write to the next write-enable assertion, at least ceil(CLK_HZ*ERASE_NS/1e9) cycles pass.
- R5: Verify of a byte is a command write of A0h with `fl_addr` equal to that byte. From the release of write-enable to the fall of `fl_oe_n`, at least ceil(CLK_HZ*VERIFY_NS/1e9) cycles pass.
- R6: A byte passes when `fl_rdata` equals FFh during the read; the controller then verifies the next address, and it finishes with success after `last_addr` passes.
- R7: On a failed byte the pulse count increments and a new erase pulse follows, after which verify resumes at the same address; with per-byte pulse needs n(a) and a peak need P, a successful run issues P erase pulses and (last_addr+1)+P-1 verify reads.
- R8: When the failure count reaches `MAX_PULSES`, the run ends with `error`, after exactly `MAX_PULSES` erase pulses; a chip needing exactly `MAX_PULSES` pulses still succeeds.
- R9: The last command write of every run, on success or error, carries data 00h.
- R10: `done` and `error` are single-cycle and never high together; `stat_pass`/`stat_fail` keep the last outcome until the next accepted start.
- R11: Each command write holds `fl_addr` and `fl_wdata` stable for one cycle before `fl_we_n` falls, while it is low, and for one cycle after it rises; `fl_we_n` and `fl_oe_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse |
| last_addr | input | ADDR_W | Highest address to pre-program and verify |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_wdata | output | 8 | Flash write data (command byte) |
| fl_rdata | input | 8 | Flash read data |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| vpp_en | output | 1 | Programming-supply enable |
| pp_req | output | 1 | Request to byte-program engine to write 00h at `fl_addr` |
| pp_ack | input | 1 | One-cycle completion from byte-program engine |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle pulse-budget failure |
| stat_pass | output | 1 | Sticky: last run succeeded |
| stat_fail | output | 1 | Sticky: last run failed |

## Verification
Two events can fall in the same cycle: a new `start` request and the final cycle of a run, where `done` or `error` is shown. The bench provokes this by raising `start` at the very sample where it sees `done` high. It judges the outcome one cycle later: `busy` and `vpp_en` must be low, the status must still read pass, and no pre-program request may appear. A second collision is the last failed compare meeting the pulse limit. The bench places a high pulse need on the final address and at exactly the limit, so the error or success decision falls in the same cycle as the last-address test.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int ADDR_W     = 16,
  parameter int CLK_HZ     = 50_000_000,
  parameter int ERASE_NS   = 10_000_000,
  parameter int VERIFY_NS  = 6_000,
  parameter int MAX_PULSES = 3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] last_addr,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  input  logic [7:0]        fl_rdata,
  output logic              fl_we_n,
  output logic              fl_oe_n,
  output logic              vpp_en,
  output logic              pp_req,
  input  logic              pp_ack,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              stat_pass,
  output logic              stat_fail
);

  localparam longint ER_RAW = (longint'(CLK_HZ) * ERASE_NS  + 64'd999_999_999) / 64'd1_000_000_000;
  localparam longint VF_RAW = (longint'(CLK_HZ) * VERIFY_NS + 64'd999_999_999) / 64'd1_000_000_000;
  localparam longint ER_CYC = (ER_RAW < 1) ? 1 : ER_RAW;
  localparam longint VF_CYC = (VF_RAW < 1) ? 1 : VF_RAW;
  localparam longint TMAX   = (ER_CYC > VF_CYC) ? ER_CYC : VF_CYC;
  localparam int     TW     = $clog2(TMAX + 1);
  localparam int     PW     = $clog2(MAX_PULSES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PREP, S_ESET, S_ERUN, S_EWAIT,
    S_VCMD, S_VWAIT, S_READ, S_RCMD, S_FIN
  } st_t;

  st_t              st;
  logic [1:0]       ph;
  logic [TW-1:0]    tmr;
  logic [PW-1:0]    pcnt;
  logic [ADDR_W-1:0] addr;
  logic             fail_r;

  wire wr_st   = (st == S_ESET) || (st == S_ERUN) || (st == S_VCMD) || (st == S_RCMD);
  wire wr_end  = (ph == 2'd2);
  wire at_last = (addr == last_addr);

  assign fl_addr = addr;
  assign fl_we_n = !(wr_st && ph == 2'd1);
  assign fl_oe_n = (st != S_READ);
  assign pp_req  = (st == S_PREP);
  assign busy    = (st != S_IDLE);
  assign done    = (st == S_FIN) && stat_pass;
  assign error   = (st == S_FIN) && stat_fail;

  always_comb begin
    case (st)
      S_ESET, S_ERUN: fl_wdata = 8'h20;
      S_VCMD:         fl_wdata = 8'hA0;
      default:        fl_wdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ph        <= '0;
      tmr       <= '0;
      pcnt      <= '0;
      addr      <= '0;
      fail_r    <= 1'b0;
      vpp_en    <= 1'b0;
      stat_pass <= 1'b0;
      stat_fail <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          vpp_en    <= 1'b1;
          addr      <= '0;
          pcnt      <= '0;
          ph        <= '0;
          fail_r    <= 1'b0;
          stat_pass <= 1'b0;
          stat_fail <= 1'b0;
          st        <= S_PREP;
        end
        S_PREP: if (pp_ack) begin
          if (at_last) begin
            addr <= '0;
            st   <= S_ESET;
          end else begin
            addr <= addr + 1'b1;
          end
        end
        S_ESET: begin
          ph <= wr_end ? 2'd0 : ph + 2'd1;
          if (wr_end) st <= S_ERUN;
        end
        S_ERUN: begin
          ph <= wr_end ? 2'd0 : ph + 2'd1;
          if (wr_end) begin
            tmr <= TW'(ER_CYC);
            st  <= S_EWAIT;
          end
        end
        S_EWAIT: begin
          tmr <= tmr - 1'b1;
          if (tmr == TW'(1)) st <= S_VCMD;
        end
        S_VCMD: begin
          ph <= wr_end ? 2'd0 : ph + 2'd1;
          if (wr_end) begin
            tmr <= TW'(VF_CYC);
            st  <= S_VWAIT;
          end
        end
        S_VWAIT: begin
          tmr <= tmr - 1'b1;
          if (tmr == TW'(1)) st <= S_READ;
        end
        S_READ: begin
          ph <= (ph == 2'd1) ? 2'd0 : ph + 2'd1;
          if (ph == 2'd1) begin
            if (fl_rdata == 8'hFF) begin
              if (at_last) begin
                st <= S_RCMD;
              end else begin
                addr <= addr + 1'b1;
                st   <= S_VCMD;
              end
            end else begin
              pcnt <= pcnt + 1'b1;
              if (pcnt == PW'(MAX_PULSES - 1)) begin
                fail_r <= 1'b1;
                st     <= S_RCMD;
              end else begin
                st <= S_ESET;
              end
            end
          end
        end
        S_RCMD: begin
          ph <= wr_end ? 2'd0 : ph + 2'd1;
          if (wr_end) begin
            vpp_en    <= 1'b0;
            stat_pass <= !fail_r;
            stat_fail <= fail_r;
            st        <= S_FIN;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R3
  vpp_during_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> vpp_en);

  // R3
  vpp_off_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> !vpp_en);

  // R4
  wait_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EWAIT || st == S_VWAIT) |-> tmr != '0);

  // R8
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= PW'(MAX_PULSES));

  // R10
  end_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, error}));

  // R10
  end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |=> !(done || error));

  // R11
  we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> ($stable(fl_addr) && $stable(fl_wdata)));

  // R11
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_wdata)));

  // R11
  no_bus_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));

endmodule

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb_top;
  localparam int AW   = 4;
  localparam int MAXP = 4;
  localparam int ER_EXP = 40;  // 1 MHz * 40 us
  localparam int VF_EXP = 6;   // ceil(1 MHz * 5.5 us)

  // {last[16:13], peak_addr[12:9], peak_need[8:5], base_need[4:1], exp_err[0]}
  localparam logic [16:0] VEC [6] = '{
    {4'd0,  4'd0,  4'd1, 4'd1, 1'b0},
    {4'd7,  4'd3,  4'd3, 4'd1, 1'b0},
    {4'd15, 4'd15, 4'd2, 4'd1, 1'b0},
    {4'd5,  4'd0,  4'd4, 4'd2, 1'b0},
    {4'd5,  4'd2,  4'd5, 4'd1, 1'b1},
    {4'd9,  4'd9,  4'd4, 4'd3, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pp_ack = 1'b0;
  logic [AW-1:0] last_addr = '0;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata;
  logic fl_we_n, fl_oe_n, vpp_en, pp_req, busy, done, error, stat_pass, stat_fail;

  always #4 clk = ~clk;

  flash_erase_seq #(.ADDR_W(AW), .CLK_HZ(1_000_000), .ERASE_NS(40_000),
                    .VERIFY_NS(5_500), .MAX_PULSES(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .last_addr(last_addr),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .vpp_en(vpp_en), .pp_req(pp_req),
    .pp_ack(pp_ack), .busy(busy), .done(done), .error(error),
    .stat_pass(stat_pass), .stat_fail(stat_fail));

  int checks = 0, fails = 0;
  bit finished = 0;

  // flash model
  logic [7:0] mem [16];
  int need [16];
  int ecnt [16];
  logic [AW-1:0] vaddr = '0;
  logic [7:0] last_cmd = 8'hFF;
  bit armed = 0;
  int erase_cnt = 0, reads = 0, pp_cnt = 0, pp_at_erase = -1;
  int pp_order_bad = 0, zero_bad = 0;
  int kind = 0;  // 1 erase, 2 verify
  int gap = 0, tim_bad = 0, frame_bad = 0;
  logic prev_we = 1'b1, prev_oe = 1'b1;
  logic [AW-1:0] prev_a = '0;
  logic [7:0] prev_d = '0;
  int cur_last = 0;
  int pp_hold = 0;

  assign fl_rdata = mem[vaddr];

  always @(posedge fl_we_n) begin
    kind = 0;
    if (fl_wdata == 8'h20) begin
      if (armed) begin
        armed = 0;
        if (erase_cnt == 0) begin
          pp_at_erase = pp_cnt;
          for (int a = 0; a <= cur_last; a++) if (mem[a] != 8'h00) zero_bad++;
        end
        erase_cnt++;
        kind = 1;
        for (int a = 0; a < 16; a++) begin
          ecnt[a]++;
          if (ecnt[a] >= need[a]) mem[a] = 8'hFF;
        end
      end else armed = 1;
    end else begin
      armed = 0;
      if (fl_wdata == 8'hA0) begin vaddr = fl_addr; kind = 2; end
    end
    last_cmd = fl_wdata;
  end

  always @(negedge fl_oe_n) reads++;

  // byte-program engine model and strobe monitors
  always @(negedge clk) begin
    if (pp_ack) begin
      pp_ack = 1'b0;
      pp_hold = 0;
    end else if (pp_req) begin
      pp_hold++;
      if (pp_hold == 3) begin
        if (int'(fl_addr) != pp_cnt) pp_order_bad++;
        mem[fl_addr] = 8'h00;
        pp_cnt++;
        pp_ack = 1'b1;
      end
    end
    if (!fl_we_n) begin
      if (prev_we) begin
        if (kind == 1 && gap < ER_EXP) tim_bad++;
      end
      if (fl_addr != prev_a || fl_wdata != prev_d) frame_bad++;
      gap = 0;
    end else if (!prev_we) begin
      if (fl_addr != prev_a || fl_wdata != prev_d) frame_bad++;
      gap = 1;
    end else if (!fl_oe_n) begin
      if (prev_oe && kind == 2 && gap < VF_EXP) tim_bad++;
      if (prev_oe) kind = 0;
    end else gap++;
    if (!fl_we_n && !fl_oe_n) frame_bad++;
    prev_we = fl_we_n; prev_oe = fl_oe_n; prev_a = fl_addr; prev_d = fl_wdata;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input int last, output int pulses, output int rds, output bit err);
    pulses = 1; rds = 0; err = 0;
    for (int a = 0; a <= last && !err; a++) begin
      forever begin
        rds++;
        if (pulses >= need[a]) break;
        if (pulses == MAXP) begin err = 1; break; end
        pulses++;
      end
    end
  endtask

  task automatic run_case(input int idx, input bit inj_busy, input bit poke_done);
    logic [16:0] v = VEC[idx];
    int last = int'(v[16:13]);
    int exp_p, exp_r;
    bit exp_e, m_e;
    bit injected = 0;
    for (int a = 0; a < 16; a++) begin
      need[a] = (a == int'(v[12:9])) ? int'(v[8:5]) : int'(v[4:1]);
      if (a > last) need[a] = 1;
      mem[a] = 8'(a * 37 + 5);
      ecnt[a] = 0;
    end
    exp_e = v[0];
    model(last, exp_p, exp_r, m_e);
    erase_cnt = 0; reads = 0; pp_cnt = 0; pp_at_erase = -1; zero_bad = 0;
    pp_order_bad = 0; tim_bad = 0; frame_bad = 0; cur_last = last; armed = 0;
    last_addr = AW'(last);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy && !stat_pass && !stat_fail, "R1 start accepted, status cleared", busy, 1);
    chk(vpp_en, "R3 supply enabled after start", vpp_en, 1);
    while (!(done || error)) begin
      @(negedge clk);
      if (inj_busy && !injected && erase_cnt == 1) begin
        start = 1'b1; injected = 1;
        @(negedge clk) start = 1'b0;
      end
    end
    chk(error == exp_e && done == !exp_e, "R8/R6 outcome", error, exp_e);
    chk(m_e == exp_e, "R8 model agrees with vector", m_e, exp_e);
    chk(!vpp_en, "R3 supply off at end pulse", vpp_en, 0);
    chk(last_cmd == 8'h00, "R9 final command", last_cmd, 0);
    chk(pp_at_erase == last + 1 && pp_cnt == last + 1, "R2 pre-program before erase",
        pp_at_erase, last + 1);
    chk(zero_bad == 0 && pp_order_bad == 0, "R2 bytes zero and ordered", zero_bad + pp_order_bad, 0);
    chk(erase_cnt == (exp_e ? MAXP : exp_p), "R7 erase pulse count", erase_cnt, exp_e ? MAXP : exp_p);
    chk(reads == exp_r, "R7 verify reads resume at failing byte", reads, exp_r);
    chk(tim_bad == 0, "R4/R5 wait windows", tim_bad, 0);
    chk(frame_bad == 0, "R11 write framing", frame_bad, 0);
    if (!exp_e) begin
      int nff = 0;
      for (int a = 0; a <= last; a++) if (mem[a] != 8'hFF) nff++;
      chk(nff == 0, "R6 all bytes erased", nff, 0);
    end
    if (poke_done) begin
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(!busy && !vpp_en, "R1 start on end cycle ignored", busy, 0);
    end else begin
      @(negedge clk);
      chk(!done && !error, "R10 end pulse single cycle", done | error, 0);
    end
    repeat (4) @(negedge clk);
    chk(stat_pass == !exp_e && stat_fail == exp_e && !pp_req, "R10 sticky status",
        stat_fail, exp_e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(fl_we_n && fl_oe_n && !vpp_en && !busy && !pp_req && !done && !error,
        "R3 reset state", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!stat_pass && !stat_fail, "R10 status clear after reset", stat_pass, 0);
    for (int i = 0; i < 6; i++) run_case(i, 1'b0, 1'b0);
    run_case(1, 1'b1, 1'b0);   // R1 start while busy
    run_case(3, 1'b0, 1'b1);   // R1 start on done cycle
    run_case(4, 1'b0, 1'b0);   // R8 error, then status
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule